// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This unit owns the program counter of a single-cycle processor and works out, every clock, where the following instruction lives. The counter is stored as a word address, so it has no byte-offset bits. The byte address sent to instruction memory is that word address with two zero bits appended at the bottom.

On each rising edge the unit chooses one of three next-address paths:

- **SEQUENTIAL** advances one word.
- **BRANCH** adds a signed 16-bit word offset taken from the instruction. The offset is added to the already advanced address.
- **JUMP** keeps the upper region bits of the current counter and replaces everything below them with the 26-bit target field of the instruction.

The choice comes from the branch and jump controls and the ALU zero flag:

- SEQUENTIAL is chosen when neither control is set, or when a branch is requested and the zero flag is low.
- BRANCH is chosen when a branch is requested and the zero flag is high.
- JUMP is chosen whenever the jump control is set, whatever the other two inputs are.

A synchronous reset overrides all three paths and loads zero.

Top module: `ifu_nextpc`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is loaded with zero, so `imem_addr` reads 0x00000000 after that edge, whatever the control inputs are.
- R2: Bits 1:0 of `imem_addr` are always 00.
- R3: With `branch_en`=0 and `jump_en`=0, `imem_addr` increases by 4 at each rising edge.
- R4: With `branch_en`=1, `alu_zero`=1 and `jump_en`=0, the next address is the current address + 4 + (sign-extended `instr[15:0]` × 4).
- R5: With `branch_en`=1, `alu_zero`=0 and `jump_en`=0, the next address is the current address + 4.
- R6: With `jump_en`=1, the next address is {current `imem_addr[31:28]`, `instr[25:0]`, 2'b00}.
- R7: When `jump_en`=1, the jump result is taken even if `branch_en`=1 and `alu_zero`=1.
- R8: The branch offset is relative to the incremented address. An offset of 0 gives current + 4, and an offset of 0xFFFF (−1) gives the current address again.
- R9: Address arithmetic wraps modulo 2^32. A step from 0xFFFFFFFC gives 0x00000000, and a backward branch below zero wraps to the top of the space.
- R10: When `branch_en`=0, `alu_zero` and `instr[15:0]` have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| branch_en | input | 1 | Conditional branch requested |
| jump_en | input | 1 | Absolute jump requested |
| alu_zero | input | 1 | ALU zero flag for the branch compare |
| instr | input | 32 | Current instruction word |
| imem_addr | output | 32 | Byte address of the current instruction |

## Verification
The assertions take for granted that `branch_en`, `jump_en`, `alu_zero` and `instr` carry known values at every rising edge after reset. They also assume that reset is the only way the counter leaves the three named paths. The stimulus respects this: every control input and the instruction word are driven to defined values at the falling edge, including during reset. The reset cycles are themselves driven with a jump request, to show that reset wins.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    // Width of a byte address and of the instruction fields that steer the next address
    parameter int ADDR_W  = 32;
    parameter int INSTR_W = 32;
    parameter int IMM_W   = 16;
    parameter int TGT_W   = 26;

    // Two byte-offset bits are never stored
    localparam int BYTE_OFS_W = 2;
    localparam int WORD_W     = ADDR_W - BYTE_OFS_W;
    localparam int REGION_W   = WORD_W - TGT_W;

    // Which path feeds the counter on the next edge
    typedef enum logic [1:0] {
        SEL_SEQUENTIAL = 2'd0,
        SEL_BRANCH     = 2'd1,
        SEL_JUMP       = 2'd2
    } next_sel_e;

endpackage

// File: rtl/ifu_seq_adder.sv
module ifu_seq_adder #(
    parameter int WORD_W = 30
) (
    input  logic [WORD_W-1:0] pc_word,
    output logic [WORD_W-1:0] pc_next_seq
);

    localparam logic [WORD_W-1:0] ONE_WORD = WORD_W'(1);

    // One word ahead; the carry out of the top bit is dropped (modulo wrap)
    always_comb begin
        pc_next_seq = pc_word + ONE_WORD;
    end

endmodule

// File: rtl/ifu_branch_target.sv
module ifu_branch_target #(
    parameter int WORD_W = 30,
    parameter int IMM_W  = 16
) (
    input  logic [WORD_W-1:0] pc_next_seq,
    input  logic [IMM_W-1:0]  offset_imm,
    output logic [WORD_W-1:0] branch_word
);

    logic [WORD_W-1:0] offset_ext;

    // Sign extension variant picked by the relative widths
    generate
        if (WORD_W > IMM_W) begin : g_extend
            always_comb begin
                offset_ext = {{(WORD_W-IMM_W){offset_imm[IMM_W-1]}}, offset_imm};
            end
        end else begin : g_trunc
            always_comb begin
                offset_ext = offset_imm[WORD_W-1:0];
            end
        end
    endgenerate

    // Offset counts words and is applied after the sequential step
    always_comb begin
        branch_word = pc_next_seq + offset_ext;
    end

endmodule

// File: rtl/ifu_jump_target.sv
module ifu_jump_target #(
    parameter int WORD_W = 30,
    parameter int TGT_W  = 26
) (
    input  logic [WORD_W-1:0] pc_word,
    input  logic [TGT_W-1:0]  target_field,
    output logic [WORD_W-1:0] jump_word
);

    localparam int REGION_W = WORD_W - TGT_W;

    // Region bits come from the counter as it stands this cycle
    generate
        if (REGION_W > 0) begin : g_region
            always_comb begin
                jump_word = {pc_word[WORD_W-1:TGT_W], target_field};
            end
        end else begin : g_flat
            always_comb begin
                jump_word = target_field[WORD_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/ifu_next_sel.sv
module ifu_next_sel
    import ifu_pkg::*;
#(
    parameter int WORD_W = 30
) (
    input  logic              branch_en,
    input  logic              jump_en,
    input  logic              alu_zero,
    input  logic [WORD_W-1:0] seq_word,
    input  logic [WORD_W-1:0] branch_word,
    input  logic [WORD_W-1:0] jump_word,
    output logic [WORD_W-1:0] next_word
);

    next_sel_e sel;

    // Path decision: jump outranks a taken branch
    always_comb begin
        if (jump_en) begin
            sel = SEL_JUMP;
        end else if (branch_en && alu_zero) begin
            sel = SEL_BRANCH;
        end else begin
            sel = SEL_SEQUENTIAL;
        end
    end

    // Multiplexer driven by the named path
    always_comb begin
        unique case (sel)
            SEL_JUMP:   next_word = jump_word;
            SEL_BRANCH: next_word = branch_word;
            default:    next_word = seq_word;
        endcase
    end

endmodule

// File: rtl/ifu_nextpc.sv
module ifu_nextpc
    import ifu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               branch_en,
    input  logic               jump_en,
    input  logic               alu_zero,
    input  logic [INSTR_W-1:0] instr,
    output logic [ADDR_W-1:0]  imem_addr
);

    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] seq_word;
    logic [WORD_W-1:0] branch_word;
    logic [WORD_W-1:0] jump_word;
    logic [WORD_W-1:0] next_word;
    logic              unused_opcode;

    assign unused_opcode = ^instr[INSTR_W-1:TGT_W];

    ifu_seq_adder #(.WORD_W(WORD_W)) u_seq (
        .pc_word     (pc_q),
        .pc_next_seq (seq_word)
    );

    ifu_branch_target #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_branch (
        .pc_next_seq (seq_word),
        .offset_imm  (instr[IMM_W-1:0]),
        .branch_word (branch_word)
    );

    ifu_jump_target #(.WORD_W(WORD_W), .TGT_W(TGT_W)) u_jump (
        .pc_word      (pc_q),
        .target_field (instr[TGT_W-1:0]),
        .jump_word    (jump_word)
    );

    ifu_next_sel #(.WORD_W(WORD_W)) u_sel (
        .branch_en   (branch_en),
        .jump_en     (jump_en),
        .alu_zero    (alu_zero),
        .seq_word    (seq_word),
        .branch_word (branch_word),
        .jump_word   (jump_word),
        .next_word   (next_word)
    );

    // Counter register with synchronous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= next_word;
        end
    end

    // Byte address: word address with a zero byte offset
    always_comb begin
        imem_addr = {pc_q, {BYTE_OFS_W{1'b0}}};
    end

endmodule

// File: rtl/ifu_nextpc_chk.sv
module ifu_nextpc_chk
    import ifu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               branch_en,
    input logic               jump_en,
    input logic               alu_zero,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  imem_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    function automatic logic [ADDR_W-1:0] byte_offset(input logic [IMM_W-1:0] imm);
        return ADDR_W'({{(ADDR_W-IMM_W-BYTE_OFS_W){imm[IMM_W-1]}}, imm, {BYTE_OFS_W{1'b0}}});
    endfunction

    logic rst_d = 1'b0;
    always @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d) begin
            AST_RESET_ZERO: assert (imem_addr == '0) else $error("reset value");  // R1
        end
    end

    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        imem_addr[BYTE_OFS_W-1:0] == '0);  // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!branch_en && !jump_en) |=> imem_addr == $past(imem_addr) + STEP);  // R3

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (branch_en && alu_zero && !jump_en) |=>
        imem_addr == $past(imem_addr) + STEP + byte_offset($past(instr[IMM_W-1:0])));  // R4

    AST_BRANCH_UNTAKEN: assert property (@(posedge clk) disable iff (rst)
        (branch_en && !alu_zero && !jump_en) |=> imem_addr == $past(imem_addr) + STEP);  // R5

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        jump_en |=> imem_addr == {$past(imem_addr[ADDR_W-1:ADDR_W-REGION_W]),
                                  $past(instr[TGT_W-1:0]), {BYTE_OFS_W{1'b0}}});  // R6

    AST_JUMP_OVER_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (jump_en && branch_en && alu_zero) |=>
        imem_addr[ADDR_W-REGION_W-1:0] == {$past(instr[TGT_W-1:0]), {BYTE_OFS_W{1'b0}}});  // R7

endmodule

bind ifu_nextpc ifu_nextpc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .branch_en (branch_en),
    .jump_en   (jump_en),
    .alu_zero  (alu_zero),
    .instr     (instr),
    .imem_addr (imem_addr)
);

// File: tb/ifu_nextpc_bench.sv
module ifu_nextpc_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        branch_en;
    logic        jump_en;
    logic        alu_zero;
    logic [31:0] instr;
    logic [31:0] imem_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [29:0] model_pc;

    always #10 clk = ~clk;  // 50 MHz

    ifu_nextpc u_ifu_nextpc (
        .clk       (clk),
        .rst       (rst),
        .branch_en (branch_en),
        .jump_en   (jump_en),
        .alu_zero  (alu_zero),
        .instr     (instr),
        .imem_addr (imem_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Driver: reset cycle, expected value pushed to the scoreboard
    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1; jump_en = 1'b1; branch_en = 1'b1; alu_zero = 1'b1;
        instr = 32'h0BFF_FFFF;
        model_pc = '0;
        exp_q.push_back({model_pc, 2'b00});
        tag_q.push_back(req);
    endtask

    // Driver: one instruction, model advanced from the requirements
    task automatic step(input string req, input logic br, input logic jp,
                        input logic z, input logic [31:0] ins);
        logic [29:0] inc;
        @(negedge clk);
        rst = 1'b0; branch_en = br; jump_en = jp; alu_zero = z; instr = ins;
        inc = model_pc + 30'd1;
        if (jp)            model_pc = {model_pc[29:26], ins[25:0]};
        else if (br && z)  model_pc = inc + {{14{ins[15]}}, ins[15:0]};
        else               model_pc = inc;
        exp_q.push_back({model_pc, 2'b00});
        tag_q.push_back(req);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), imem_addr, exp_q.pop_front());
                check("R2", {30'd0, imem_addr[1:0]}, 32'd0);
            end
        end
    end

    initial begin
        rst = 1'b1; branch_en = 1'b0; jump_en = 1'b0; alu_zero = 1'b0; instr = '0;
        do_reset("R1");
        do_reset("R1");
        step("R3", 0, 0, 0, 32'h0000_0000);
        step("R3", 0, 0, 0, 32'h1234_5678);
        step("R3", 0, 0, 0, 32'hFFFF_FFFF);
        step("R10", 0, 0, 1, 32'h1000_0010);   // zero high, no branch
        step("R10", 0, 0, 1, 32'h1000_FFF0);
        step("R5", 1, 0, 0, 32'h1000_0100);
        step("R4", 1, 0, 1, 32'h1000_0003);
        step("R8", 1, 0, 1, 32'h1000_0000);    // offset 0 gives +4
        step("R8", 1, 0, 1, 32'h1000_FFFF);    // offset -1 stays put
        step("R6", 0, 1, 0, 32'h0800_0100);
        step("R7", 1, 1, 1, 32'h0800_0200);    // jump wins over taken branch
        step("R9", 1, 0, 1, 32'h1000_FDFE);    // backward below zero
        step("R6", 0, 1, 0, 32'h0800_0010);    // keeps region 0xF
        step("R6", 0, 1, 0, 32'h0BFF_FFFF);
        step("R9", 0, 0, 0, 32'h0000_0000);    // top of space wraps to 0
        step("R4", 1, 0, 1, 32'h1000_7FFF);
        step("R5", 1, 0, 0, 32'h1000_8000);
        do_reset("R1");
        step("R3", 0, 0, 0, 32'h0000_0000);
        @(negedge clk);
        rst = 1'b0; branch_en = 1'b0; jump_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule